// File: doc/BRIEF.md
# Instruction Cache Way Preload and Pin Controller

This block owns a small two-way set-associative instruction cache and the sequencer that fills it. Besides serving normal lookups, where a miss fetches the whole line from memory into a victim way, it accepts a configure command. The command carries a start address and a flag. With the flag set, the block walks every set of way 0 and loads it with consecutive lines beginning at that address. When the walk completes, way 0 is pinned. Normal misses then allocate only into way 1, so code placed in way 0 (an interrupt handler, for example) stays resident. With the flag clear, the command unpins way 0 and leaves its contents in place.

The cache does not watch writes to program memory. Once a line is held, a later change in memory never reaches it. While a preload runs, the block raises `busy` and refuses both lookups and commands. It pulses `done` as the last set is written.

Top module: `icache_lock_ctl`

## Requirements
- R1: A pin command fetches exactly SETS*WORDS words. The word addresses run consecutively, upward from the start address with its low OFF_W bits (the word-in-line offset) cleared, and wrap modulo 2^ADDR_W. The address of each word selects its set as bits [OFF_W +: IDX_W], so the walk fills every set of way 0 exactly once.
- R2: From the cycle after a pin command is accepted until the walk ends, `busy` is 1 and both `lk_ready` and `cfg_ready` are 0. `done` is high for exactly one cycle. In that cycle `locked` becomes 1 and `busy` becomes 0.
- R3: A lookup that hits returns `rsp_valid`=1 with `rsp_hit`=1 in the cycle after it is accepted. It carries the hitting way in `rsp_way` and the stored word, and it makes no memory read.
- R4: While `locked` is 1, every miss fills way 1, whatever the per-set LRU bit holds. Way 0 is never written by a miss.
- R5: While unlocked, a miss fills the way named by the per-set LRU bit. After every hit and every miss fill, that bit is set to point at the other way. A pin walk leaves the LRU bits unchanged.
- R6: Changing memory contents after a line is held does not change what a later hit on that line returns.
- R7: An unpin command clears `locked` at the next clock edge. The lines in way 0 keep hitting, and way 0 becomes an eviction candidate again under R5.
- R8: A miss reads the WORDS words of its line in ascending order. It then responds with `rsp_hit`=0, the filled way and the requested word.
- R9: If both ways hold a valid matching line, the lookup is served from way 0.
- R10: After reset the cache is empty, unlocked, and every LRU bit is 0. `busy`, `done`, `mem_req` and `rsp_valid` are 0. The first miss in any set fills way 0.
- R11: `mem_req` stays high and `mem_addr` stays stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configure command present |
| cfg_lock | input | 1 | 1 = preload way 0 and pin it, 0 = unpin |
| cfg_addr | input | ADDR_W | Word start address of the preload |
| cfg_ready | output | 1 | Command accepted this cycle when high with cfg_valid |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W | Lookup word address |
| lk_ready | output | 1 | Lookup accepted this cycle when high with lk_valid |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | 1 = served from cache without a fill |
| rsp_way | output | 1 | Way that served or received the line |
| rsp_data | output | DATA_W | Requested instruction word |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | A fill is in progress |
| done | output | 1 | One-cycle pulse at the end of a preload |
| locked | output | 1 | Way 0 is pinned |

## Verification
The hardest state to reach is a set where both ways hold the same line. A pin walk never checks for a copy already present in the other way, so a line can end up in both. The stimulus first misses on that line while unlocked, with the LRU bit steering it into way 1. A preload whose start address wraps past the last set then covers the same line in way 0, and a lookup checks that way 0 wins. A second hard point is the pinned-way guarantee. It is checked by driving three conflicting misses into one set with the LRU bit pointing at way 0, and confirming that each fill lands in way 1 and that the pinned line still hits afterwards.

// File: rtl/icl_pkg.sv
package icl_pkg;

    localparam int unsigned NUM_WAYS   = 2;
    localparam logic        PINNED_WAY = 1'b0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_MISS = 2'd2
    } icl_state_e;

    // Victim choice: a pinned cache always refills the free way.
    function automatic logic pick_victim(input logic pinned, input logic lru_bit);
        return pinned ? ~PINNED_WAY : lru_bit;
    endfunction

    // Way 0 wins when both ways match.
    function automatic logic pick_hit_way(input logic [NUM_WAYS-1:0] hits);
        return hits[0] ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/icl_store.sv
module icl_store
    import icl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 8,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned TAG_W  = 11
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(SETS)-1:0]           rd_idx,
    input  logic [TAG_W-1:0]                  rd_tag,
    input  logic [$clog2(WORDS)-1:0]          rd_off,
    output logic [NUM_WAYS-1:0]               hit_vec,
    output logic [NUM_WAYS-1:0][DATA_W-1:0]   rd_word,
    output logic                              lru_bit,
    input  logic                              wr_en,
    input  logic                              wr_way,
    input  logic [$clog2(SETS)-1:0]           wr_idx,
    input  logic [$clog2(WORDS)-1:0]          wr_off,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              cm_en,
    input  logic [TAG_W-1:0]                  cm_tag,
    input  logic                              lru_en,
    input  logic [$clog2(SETS)-1:0]           lru_idx,
    input  logic                              lru_val,
    input  logic                              pin_guard
);
    localparam int unsigned IDX_W = $clog2(SETS);

    logic [SETS-1:0] lru_q;

    assign lru_bit = lru_q[rd_idx];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [DATA_W-1:0] data_q [SETS][WORDS];
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [WORDS-1:0]  vld_q  [SETS];
        logic              sel;

        assign sel        = (wr_way == 1'(w));
        assign hit_vec[w] = vld_q[rd_idx][rd_off] && (tag_q[rd_idx] == rd_tag);
        assign rd_word[w] = data_q[rd_idx][rd_off];

        always_ff @(posedge clk) begin
            if (wr_en && sel) begin
                data_q[wr_idx][wr_off] <= wr_data;
            end
        end

        // Tag and all word-valid bits are committed when the line completes.
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    vld_q[s] <= '0;
                    tag_q[s] <= '0;
                end
            end else if (cm_en && sel) begin
                tag_q[wr_idx] <= cm_tag;
                vld_q[wr_idx] <= '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (lru_en) begin
            lru_q[lru_idx] <= lru_val;
        end
    end

    // R4: a miss fill while pinned never writes the pinned way
    a_r4_pinned_way_kept: assert property (@(posedge clk) disable iff (rst)
        (pin_guard && (wr_en || cm_en)) |-> (wr_way != PINNED_WAY));

    // R10: after reset no way reports a hit
    a_r10_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (hit_vec == '0));

    logic [IDX_W-1:0] unused_idx_chk;
    assign unused_idx_chk = lru_idx;

endmodule

// File: rtl/icl_seq.sv
module icl_seq
    import icl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 8,
    parameter int unsigned WORDS  = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_valid,
    input  logic                            cfg_lock,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] cfg_line,
    output logic                            cfg_ready,
    input  logic                            lk_valid,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] lk_line,
    input  logic [$clog2(WORDS)-1:0]        lk_off,
    output logic                            lk_ready,
    input  logic [NUM_WAYS-1:0]             hit_vec,
    input  logic [NUM_WAYS-1:0][DATA_W-1:0] rd_word,
    input  logic                            lru_bit,
    output logic                            rsp_valid,
    output logic                            rsp_hit,
    output logic                            rsp_way,
    output logic [DATA_W-1:0]               rsp_data,
    output logic                            mem_req,
    output logic [ADDR_W-1:0]               mem_addr,
    input  logic                            mem_ack,
    input  logic [DATA_W-1:0]               mem_rdata,
    output logic                            busy,
    output logic                            done,
    output logic                            locked,
    output logic                            wr_en,
    output logic                            wr_way,
    output logic [$clog2(SETS)-1:0]         wr_idx,
    output logic [$clog2(WORDS)-1:0]        wr_off,
    output logic [DATA_W-1:0]               wr_data,
    output logic                            cm_en,
    output logic [ADDR_W-$clog2(WORDS)-$clog2(SETS)-1:0] cm_tag,
    output logic                            lru_en,
    output logic [$clog2(SETS)-1:0]         lru_idx,
    output logic                            lru_val,
    output logic                            pin_guard
);
    localparam int unsigned OFF_W  = $clog2(WORDS);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_SET  = IDX_W'(SETS - 1);

    icl_state_e        state_q;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  woff_q, roff_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              way_q, lock_q, done_q;
    logic              rsp_valid_q, rsp_hit_q, rsp_way_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic idle, lk_fire, any_hit, hit_way, line_end, walk_end;

    assign idle      = (state_q == ST_IDLE);
    assign cfg_ready = idle;
    assign lk_ready  = idle && !cfg_valid;
    assign lk_fire   = lk_valid && lk_ready;
    assign any_hit   = |hit_vec;
    assign hit_way   = pick_hit_way(hit_vec);

    assign mem_req   = !idle;
    assign mem_addr  = {line_q, woff_q};
    assign wr_en     = mem_req && mem_ack;
    assign wr_way    = way_q;
    assign wr_idx    = line_q[IDX_W-1:0];
    assign wr_off    = woff_q;
    assign wr_data   = mem_rdata;
    assign line_end  = wr_en && (woff_q == LAST_WORD);
    assign walk_end  = line_end && (state_q == ST_LOAD) && (cnt_q == LAST_SET);
    assign cm_en     = line_end;
    assign cm_tag    = line_q[LINE_W-1:IDX_W];
    assign pin_guard = lock_q && (state_q == ST_MISS);

    assign lru_en    = (lk_fire && any_hit) || ((state_q == ST_MISS) && line_end);
    assign lru_idx   = lk_fire ? lk_line[IDX_W-1:0] : line_q[IDX_W-1:0];
    assign lru_val   = lk_fire ? ~hit_way : ~way_q;

    assign busy      = !idle;
    assign done      = done_q;
    assign locked    = lock_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_way   = rsp_way_q;
    assign rsp_data  = rsp_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            line_q      <= '0;
            woff_q      <= '0;
            roff_q      <= '0;
            cnt_q       <= '0;
            way_q       <= 1'b0;
            lock_q      <= 1'b0;
            done_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_way_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            done_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cfg_valid) begin
                        if (cfg_lock) begin
                            line_q  <= cfg_line;
                            woff_q  <= '0;
                            cnt_q   <= '0;
                            way_q   <= PINNED_WAY;
                            state_q <= ST_LOAD;
                        end else begin
                            lock_q  <= 1'b0;
                        end
                    end else if (lk_fire) begin
                        if (any_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b1;
                            rsp_way_q   <= hit_way;
                            rsp_data_q  <= rd_word[hit_way];
                        end else begin
                            line_q  <= lk_line;
                            roff_q  <= lk_off;
                            woff_q  <= '0;
                            way_q   <= pick_victim(lock_q, lru_bit);
                            state_q <= ST_MISS;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        woff_q <= woff_q + 1'b1;
                        if (line_end) begin
                            line_q <= line_q + 1'b1;
                            cnt_q  <= cnt_q + 1'b1;
                            if (cnt_q == LAST_SET) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                lock_q  <= 1'b1;
                            end
                        end
                    end
                end
                ST_MISS: begin
                    if (mem_ack) begin
                        woff_q <= woff_q + 1'b1;
                        if (woff_q == roff_q) begin
                            rsp_data_q <= mem_rdata;
                        end
                        if (line_end) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b0;
                            rsp_way_q   <= way_q;
                            state_q     <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: the completion pulse lasts one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: completion coincides with the pin and the end of busy
    a_r2_done_pins: assert property (@(posedge clk) disable iff (rst)
        done |-> (locked && !busy));

    // R11: a request is held with a stable address until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R1: the preload walk reads consecutive word addresses
    a_r1_consecutive: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_LOAD) && mem_ack && !walk_end) |=>
            (mem_addr == $past(mem_addr) + 1'b1));

    // R7: an unpin command clears the pin at the next edge
    a_r7_unpin: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_ready && !cfg_lock) |=> !locked);

endmodule

// File: rtl/icache_lock_ctl.sv
module icache_lock_ctl
    import icl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 8,
    parameter int unsigned WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_lock,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic              cfg_ready,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_way,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              locked
);
    localparam int unsigned OFF_W  = $clog2(WORDS);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;
    localparam int unsigned TAG_W  = LINE_W - IDX_W;

    logic [NUM_WAYS-1:0]             hit_vec;
    logic [NUM_WAYS-1:0][DATA_W-1:0] rd_word;
    logic                            lru_bit;
    logic                            wr_en, wr_way, cm_en, lru_en, lru_val, pin_guard;
    logic [IDX_W-1:0]                wr_idx, lru_idx;
    logic [OFF_W-1:0]                wr_off;
    logic [DATA_W-1:0]               wr_data;
    logic [TAG_W-1:0]                cm_tag;
    logic                            unused_cfg_off;

    assign unused_cfg_off = ^cfg_addr[OFF_W-1:0];

    icl_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_valid),
        .cfg_lock  (cfg_lock),
        .cfg_line  (cfg_addr[ADDR_W-1:OFF_W]),
        .cfg_ready (cfg_ready),
        .lk_valid  (lk_valid),
        .lk_line   (lk_addr[ADDR_W-1:OFF_W]),
        .lk_off    (lk_addr[OFF_W-1:0]),
        .lk_ready  (lk_ready),
        .hit_vec   (hit_vec),
        .rd_word   (rd_word),
        .lru_bit   (lru_bit),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_way   (rsp_way),
        .rsp_data  (rsp_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .locked    (locked),
        .wr_en     (wr_en),
        .wr_way    (wr_way),
        .wr_idx    (wr_idx),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .cm_en     (cm_en),
        .cm_tag    (cm_tag),
        .lru_en    (lru_en),
        .lru_idx   (lru_idx),
        .lru_val   (lru_val),
        .pin_guard (pin_guard)
    );

    icl_store #(
        .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_addr[OFF_W +: IDX_W]),
        .rd_tag    (lk_addr[ADDR_W-1:OFF_W+IDX_W]),
        .rd_off    (lk_addr[OFF_W-1:0]),
        .hit_vec   (hit_vec),
        .rd_word   (rd_word),
        .lru_bit   (lru_bit),
        .wr_en     (wr_en),
        .wr_way    (wr_way),
        .wr_idx    (wr_idx),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .cm_en     (cm_en),
        .cm_tag    (cm_tag),
        .lru_en    (lru_en),
        .lru_idx   (lru_idx),
        .lru_val   (lru_val),
        .pin_guard (pin_guard)
    );

endmodule

// File: tb/tb_icache_lock_ctl.sv
module tb_icache_lock_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int SETS   = 8;
    localparam int WORDS  = 4;
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_valid = 1'b0, cfg_lock = 1'b0, lk_valid = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0, lk_addr = '0;
    logic cfg_ready, lk_ready, rsp_valid, rsp_hit, rsp_way, mem_req, busy, done, locked;
    logic [DATA_W-1:0] rsp_data, mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_ack;

    int checks = 0;
    int errs   = 0;
    int seed   = 1;

    // behavioural model of the cache
    bit               m_vld  [2][SETS];
    int               m_tag  [2][SETS];
    logic [DATA_W-1:0] m_data [2][SETS][WORDS];
    bit               m_lru  [SETS];
    bit               m_lock;
    logic [ADDR_W-1:0] log_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_lock_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) dut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_lock(cfg_lock), .cfg_addr(cfg_addr),
        .cfg_ready(cfg_ready), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .locked(locked));

    function automatic logic [DATA_W-1:0] memval(input logic [ADDR_W-1:0] a);
        return {16'(seed), 16'(a)};
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        return ADDR_W'((tag << (OFF_W + IDX_W)) | (idx << OFF_W) | off);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory: answers each request after a two-cycle wait
    int dly = 0;
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            dly <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (dly == 1) begin
                    mem_ack   <= 1'b1;
                    mem_rdata <= memval(mem_addr);
                    log_q.push_back(mem_addr);
                    dly <= 0;
                end else begin
                    dly <= dly + 1;
                end
            end
        end
    end

    // every clock: a running fill blocks both request channels (R2)
    always @(negedge clk) begin
        if (!rst && busy) chk(!lk_ready && !cfg_ready, "R2 stall while busy", {lk_ready, cfg_ready}, 0);
    end

    task automatic do_pin(input logic [ADDR_W-1:0] a);
        int n = 0;
        int base;
        log_q.delete();
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_valid = 1'b1; cfg_lock = 1'b1; cfg_addr = a;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after pin command", busy, 1);
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(locked == 1'b1 && busy == 1'b0, "R2 pinned at done", {locked, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0, "R2 done is one cycle", done, 0);
        chk(log_q.size() == SETS * WORDS, "R1 word count", log_q.size(), SETS * WORDS);
        base = (int'(a) >> OFF_W) << OFF_W;
        for (int i = 0; i < log_q.size(); i++) begin
            logic [ADDR_W-1:0] e = ADDR_W'(base + i);
            if (log_q[i] != e) chk(0, "R1 walk address", log_q[i], e);
        end
        chk(1, "R1 walk addresses", 0, 0);
        for (int k = 0; k < SETS; k++) begin
            int line = ((base >> OFF_W) + k) % (1 << (ADDR_W - OFF_W));
            int idx  = line % SETS;
            m_tag[0][idx] = line / SETS;
            m_vld[0][idx] = 1'b1;
            for (int w = 0; w < WORDS; w++) m_data[0][idx][w] = memval(ADDR_W'(line * WORDS + w));
        end
        m_lock = 1'b1;
    endtask

    task automatic do_unpin();
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_valid = 1'b1; cfg_lock = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(locked == 1'b0 && busy == 1'b0, "R7 unpin clears lock", {locked, busy}, 0);
        m_lock = 1'b0;
    endtask

    task automatic do_look(input logic [ADDR_W-1:0] a, input string req);
        int idx = int'(a[OFF_W +: IDX_W]);
        int tag = int'(a[ADDR_W-1:OFF_W+IDX_W]);
        int off = int'(a[OFF_W-1:0]);
        bit h0 = m_vld[0][idx] && m_tag[0][idx] == tag;
        bit h1 = m_vld[1][idx] && m_tag[1][idx] == tag;
        bit ehit = h0 || h1;
        bit eway = h0 ? 1'b0 : (h1 ? 1'b1 : (m_lock ? 1'b1 : m_lru[idx]));
        logic [DATA_W-1:0] edata;
        int n = 0;
        log_q.delete();
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        if (ehit) begin
            edata = m_data[eway][idx][off];
            chk(rsp_valid == 1'b1, {req, " hit latency"}, rsp_valid, 1);
        end else begin
            while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
            chk(log_q.size() == WORDS && log_q[0] == ((a >> OFF_W) << OFF_W),
                "R8 miss reads line", log_q.size(), WORDS);
            m_tag[eway][idx] = tag;
            m_vld[eway][idx] = 1'b1;
            for (int w = 0; w < WORDS; w++)
                m_data[eway][idx][w] = memval(ADDR_W'(((int'(a) >> OFF_W) << OFF_W) + w));
            edata = m_data[eway][idx][off];
        end
        chk(rsp_hit == ehit, {req, " hit flag"}, rsp_hit, ehit);
        chk(rsp_way == eway, {req, " way"}, rsp_way, eway);
        chk(rsp_data == edata, {req, " data"}, rsp_data, edata);
        if (ehit) chk(log_q.size() == 0, "R3 hit makes no read", log_q.size(), 0);
        m_lru[idx] = ~eway;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WATCHDOG", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++) for (int s = 0; s < SETS; s++) begin m_vld[w][s] = 0; m_tag[w][s] = 0; end
        for (int s = 0; s < SETS; s++) m_lru[s] = 0;
        m_lock = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !locked && !mem_req && !rsp_valid, "R10 reset outputs",
            {busy, done, locked, mem_req, rsp_valid}, 0);

        do_look(mk(1, 2, 1), "R10 first miss to way 0");
        do_look(mk(1, 2, 3), "R3 hit");
        do_look(mk(2, 2, 0), "R5 lru picks way 1");
        do_look(mk(3, 2, 0), "R5 lru picks way 0");
        do_look(mk(9, 2, 1), "R5 line placed in way 1");

        do_pin(mk(8, 5, 2));
        do_look(mk(9, 2, 1), "R9 both ways, way 0 wins");
        do_look(mk(8, 7, 3), "R3 pinned hit");
        do_look(mk(9, 4, 0), "R3 pinned hit after wrap");

        do_look(mk(20, 3, 0), "R4 pinned miss to way 1");
        do_look(mk(21, 3, 0), "R4 pinned miss to way 1 again");
        do_look(mk(22, 3, 1), "R4 third conflict");
        do_look(mk(9, 3, 2), "R4 pinned line survives");

        seed = 7;
        do_look(mk(9, 3, 2), "R6 stale data kept");
        chk(rsp_data != memval(mk(9, 3, 2)), "R6 memory change not seen", rsp_data, memval(mk(9, 3, 2)));
        do_look(mk(23, 3, 0), "R6 fresh miss sees new data");

        do_unpin();
        do_look(mk(9, 0, 0), "R7 contents stay valid");
        do_look(mk(30, 0, 0), "R7 lru way 1");
        do_look(mk(31, 0, 0), "R7 way 0 evictable");
        do_look(mk(9, 0, 0), "R7 evicted line misses");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule